// File: doc/BRIEF.md
# Battery Pack Protection Controller

This block is the digital decision core of a protection circuit for a pack of three or four lithium cells in series. Analog comparators outside the block report, per cell, whether the cell is above its over-voltage limit, below its under-voltage limit, or below the charge-permission threshold. They also report whether the sense-resistor voltage shows over-current and whether the load has been taken away. The block turns these flags into enable levels for the charge FET and the discharge FET, and it reports which protection is in force.

A fault is acted on only after it has been seen at a programmed number of consecutive sample ticks. `sample_tick` is a one-cycle strobe from a slow time base. There are three protection states, and each one has its own release rule. Over-charge ends when every over-voltage flag has stayed clear for the release count. Over-discharge ends when every under-voltage flag has stayed clear for the release count. Over-current ends only after the load-removed flag has held for the release count.

The controller has five states: OFF, NORMAL, OVCHG, OVDSG and OVCUR. The named transitions are:
- power-up (OFF to NORMAL)
- charge trip (NORMAL or OVCHG ... see below; NORMAL to OVCHG)
- discharge trip (NORMAL or OVCHG to OVDSG)
- current trip (NORMAL or OVCHG to OVCUR)
- charge release (OVCHG to NORMAL)
- discharge release (OVDSG to NORMAL)
- load release (OVCUR to NORMAL)

Top module: `bpp_ctrl`

## Requirements
- R1: While reset is active, and afterwards until `pwr_good` is high at a clock edge, both FET enables are 0 and `prot_status` is 0. At the edge where `pwr_good` is first seen high, the controller enters NORMAL, with the discharge enable at 1 and the charge enable at 1 (subject to R11). After that, `pwr_good` has no effect.
- R2: In NORMAL, an over-voltage flag on an active cell counts as qualified at the (D+1)-th consecutive tick at which it is seen high, where D is `dly_ovchg`. The controller then enters OVCHG at that edge. In OVCHG the charge enable is 0 and the discharge enable is 1.
- R3: In NORMAL or OVCHG, an under-voltage flag on an active cell qualified in the same way against `dly_ovdsg` makes the controller enter OVDSG. In OVDSG the discharge enable is 0.
- R4: In NORMAL or OVCHG, `oc_trip` qualified against `dly_ovcur` makes the controller enter OVCUR. In OVCUR the discharge enable is 0.
- R5: Any cycle in which a condition is low restarts its count from zero. Cycles without a tick neither advance the count nor break it.
- R6: OVCHG returns to NORMAL at the (R+1)-th consecutive tick with every active over-voltage flag clear, where R is `dly_release`. Counting starts only once the controller is in OVCHG.
- R7: OVDSG returns to NORMAL at the (R+1)-th consecutive tick with every active under-voltage flag clear. Counting starts only once the controller is in OVDSG.
- R8: OVCUR is left only after `load_off` has been high at R+1 consecutive ticks, counted from entry into OVCUR. The over-current flag going low does not release it.
- R9: `four_cell` = 1 uses cells 0 to 3. `four_cell` = 0 uses cells 0 to 2, and the bit-3 flags of `cell_ov`, `cell_uv` and `cell_low` have no effect.
- R10: When several faults qualify at the same edge, over-current has priority over over-discharge, and over-discharge has priority over over-charge.
- R11: When `low_chg_allow` = 0 and any active cell has its `cell_low` bit set, the charge enable is 0 in every state. When `low_chg_allow` = 1, `cell_low` has no effect.
- R12: `prot_status` bit 0 is high in OVCHG, bit 1 is high in OVDSG, and bit 2 is high in OVCUR. At most one bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle sampling strobe |
| pwr_good | input | 1 | Supply is stable; allows leaving OFF |
| four_cell | input | 1 | 1 = four cells, 0 = three cells |
| cell_ov | input | NCELL | Per-cell over-voltage flags |
| cell_uv | input | NCELL | Per-cell under-voltage flags |
| cell_low | input | NCELL | Per-cell below-charge-threshold flags |
| low_chg_allow | input | 1 | 1 allows charging of cells that are below the threshold |
| oc_trip | input | 1 | Sense voltage above the over-current limit |
| load_off | input | 1 | Load resistance above the release level |
| dly_ovchg | input | DLY_W | Over-charge qualification count |
| dly_ovdsg | input | DLY_W | Over-discharge qualification count |
| dly_ovcur | input | DLY_W | Over-current qualification count |
| dly_release | input | DLY_W | Release qualification count |
| chg_fet_en | output | 1 | Charge FET enable |
| dsg_fet_en | output | 1 | Discharge FET enable |
| prot_status | output | 3 | Active protection, one-hot or zero |

## Verification
The case that matters is two or three fault counts reaching their limit on the same tick. That happens in NORMAL, and also in OVCHG while the discharge path is still live. The bench sets equal delays and raises the over-voltage, under-voltage and over-current flags in the same cycle. It then checks that the status shows only the over-current bit and that the charge enable stays on. It repeats the test without over-current and expects the over-discharge bit. The random phase flips flags slowly, so the reference model also meets trips that coincide with releases and with ticks that are missing.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_NORMAL,
        ST_OVCHG,
        ST_OVDSG,
        ST_OVCUR
    } bpp_state_e;

    localparam int STAT_W     = 3;
    localparam int STAT_OVCHG = 0;
    localparam int STAT_OVDSG = 1;
    localparam int STAT_OVCUR = 2;

    // filter slots: three fault qualifiers, three release qualifiers
    localparam int FLT_OV  = 0;
    localparam int FLT_UV  = 1;
    localparam int FLT_OC  = 2;
    localparam int REL_OV  = 3;
    localparam int REL_UV  = 4;
    localparam int REL_LD  = 5;
    localparam int N_FILT  = 6;

endpackage

// File: rtl/bpp_persist.sv
module bpp_persist #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cond,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!cond) begin
            run_q <= '0;
        end else if (tick && run_q != CNT_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // qualified when the condition is seen at limit+1 consecutive ticks
    assign hit = tick && cond && (run_q >= limit);

endmodule

// File: rtl/bpp_cell_reduce.sv
module bpp_cell_reduce #(
    parameter int NCELL = 4
) (
    input  logic             full_mode,
    input  logic [NCELL-1:0] ov,
    input  logic [NCELL-1:0] uv,
    input  logic [NCELL-1:0] low,
    output logic             ov_any,
    output logic             uv_any,
    output logic             low_any
);
    logic [NCELL-1:0] active;

    generate
        for (genvar c = 0; c < NCELL; c++) begin : g_mask
            if (c == NCELL - 1) begin : g_top
                assign active[c] = full_mode;
            end else begin : g_low
                assign active[c] = 1'b1;
            end
        end
    endgenerate

    assign ov_any  = |(ov  & active);
    assign uv_any  = |(uv  & active);
    assign low_any = |(low & active);

endmodule

// File: rtl/bpp_fsm.sv
module bpp_fsm
    import bpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              ov_trip,
    input  logic              uv_trip,
    input  logic              oc_trip_q,
    input  logic              ov_rel,
    input  logic              uv_rel,
    input  logic              ld_rel,
    input  logic              chg_inhibit,
    output bpp_state_e        state,
    output logic              chg_en,
    output logic              dsg_en,
    output logic [STAT_W-1:0] status
);
    bpp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (pwr_good) state_d = ST_NORMAL;           // power-up
            end
            ST_NORMAL: begin
                if (oc_trip_q)    state_d = ST_OVCUR;        // current trip
                else if (uv_trip) state_d = ST_OVDSG;        // discharge trip
                else if (ov_trip) state_d = ST_OVCHG;        // charge trip
            end
            ST_OVCHG: begin
                if (oc_trip_q)    state_d = ST_OVCUR;
                else if (uv_trip) state_d = ST_OVDSG;
                else if (ov_rel)  state_d = ST_NORMAL;       // charge release
            end
            ST_OVDSG: begin
                if (uv_rel) state_d = ST_NORMAL;             // discharge release
            end
            ST_OVCUR: begin
                if (ld_rel) state_d = ST_NORMAL;             // load release
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        chg_en = 1'b0;
        dsg_en = 1'b0;
        status = '0;
        unique case (state_q)
            ST_OFF: begin
                chg_en = 1'b0;
                dsg_en = 1'b0;
            end
            ST_NORMAL: begin
                chg_en = !chg_inhibit;
                dsg_en = 1'b1;
            end
            ST_OVCHG: begin
                chg_en = 1'b0;
                dsg_en = 1'b1;
                status[STAT_OVCHG] = 1'b1;
            end
            ST_OVDSG: begin
                chg_en = !chg_inhibit;
                dsg_en = 1'b0;
                status[STAT_OVDSG] = 1'b1;
            end
            ST_OVCUR: begin
                chg_en = !chg_inhibit;
                dsg_en = 1'b0;
                status[STAT_OVCUR] = 1'b1;
            end
            default: begin
                chg_en = 1'b0;
                dsg_en = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bpp_ctrl.sv
module bpp_ctrl
    import bpp_pkg::*;
#(
    parameter int NCELL = 4,
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              pwr_good,
    input  logic              four_cell,
    input  logic [NCELL-1:0]  cell_ov,
    input  logic [NCELL-1:0]  cell_uv,
    input  logic [NCELL-1:0]  cell_low,
    input  logic              low_chg_allow,
    input  logic              oc_trip,
    input  logic              load_off,
    input  logic [DLY_W-1:0]  dly_ovchg,
    input  logic [DLY_W-1:0]  dly_ovdsg,
    input  logic [DLY_W-1:0]  dly_ovcur,
    input  logic [DLY_W-1:0]  dly_release,
    output logic              chg_fet_en,
    output logic              dsg_fet_en,
    output logic [STAT_W-1:0] prot_status
);
    logic ov_any, uv_any, low_any;
    bpp_state_e state;

    logic [N_FILT-1:0] filt_cond;
    logic [N_FILT-1:0] filt_hit;
    logic [DLY_W-1:0]  filt_lim [N_FILT];

    bpp_cell_reduce #(.NCELL(NCELL)) u_reduce (
        .full_mode (four_cell),
        .ov        (cell_ov),
        .uv        (cell_uv),
        .low       (cell_low),
        .ov_any    (ov_any),
        .uv_any    (uv_any),
        .low_any   (low_any)
    );

    // release counters run only inside their own protection state
    always_comb begin
        filt_cond[FLT_OV] = ov_any;
        filt_cond[FLT_UV] = uv_any;
        filt_cond[FLT_OC] = oc_trip;
        filt_cond[REL_OV] = !ov_any && (state == ST_OVCHG);
        filt_cond[REL_UV] = !uv_any && (state == ST_OVDSG);
        filt_cond[REL_LD] = load_off && (state == ST_OVCUR);
        filt_lim[FLT_OV]  = dly_ovchg;
        filt_lim[FLT_UV]  = dly_ovdsg;
        filt_lim[FLT_OC]  = dly_ovcur;
        filt_lim[REL_OV]  = dly_release;
        filt_lim[REL_UV]  = dly_release;
        filt_lim[REL_LD]  = dly_release;
    end

    generate
        for (genvar f = 0; f < N_FILT; f++) begin : g_filt
            bpp_persist #(.CNT_W(DLY_W)) u_persist (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (sample_tick),
                .cond  (filt_cond[f]),
                .limit (filt_lim[f]),
                .hit   (filt_hit[f])
            );
        end
    endgenerate

    bpp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .ov_trip     (filt_hit[FLT_OV]),
        .uv_trip     (filt_hit[FLT_UV]),
        .oc_trip_q   (filt_hit[FLT_OC]),
        .ov_rel      (filt_hit[REL_OV]),
        .uv_rel      (filt_hit[REL_UV]),
        .ld_rel      (filt_hit[REL_LD]),
        .chg_inhibit (!low_chg_allow && low_any),
        .state       (state),
        .chg_en      (chg_fet_en),
        .dsg_en      (dsg_fet_en),
        .status      (prot_status)
    );

endmodule

// File: rtl/bpp_ctrl_chk.sv
module bpp_ctrl_chk #(
    parameter int NCELL = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic             four_cell,
    input logic [NCELL-1:0] cell_low,
    input logic             low_chg_allow,
    input logic             chg_fet_en,
    input logic             dsg_fet_en,
    input logic [2:0]       prot_status
);
    logic [NCELL-1:0] act_cells;
    assign act_cells = four_cell ? {NCELL{1'b1}} : {1'b0, {(NCELL-1){1'b1}}};

    assert_status_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prot_status));

    assert_off_both_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_status == 3'b000 && !dsg_fet_en) |-> !chg_fet_en);

    assert_ovchg_blocks_charge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prot_status[0] |-> (!chg_fet_en && dsg_fet_en));

    assert_dsg_faults_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_status[1] || prot_status[2]) |-> !dsg_fet_en);

    assert_status_moves_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_status) |-> $past(sample_tick));

    assert_low_cell_inhibit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_chg_allow && |(cell_low & act_cells)) |-> !chg_fet_en);

endmodule

bind bpp_ctrl bpp_ctrl_chk #(.NCELL(NCELL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_tick   (sample_tick),
    .four_cell     (four_cell),
    .cell_low      (cell_low),
    .low_chg_allow (low_chg_allow),
    .chg_fet_en    (chg_fet_en),
    .dsg_fet_en    (dsg_fet_en),
    .prot_status   (prot_status)
);

// File: tb/bpp_ctrl_test.sv
`timescale 1ns/1ps
module bpp_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       pwr_good = 1'b0;
    logic       four_cell = 1'b1;
    logic [3:0] cell_ov = '0, cell_uv = '0, cell_low = '0;
    logic       low_chg_allow = 1'b1;
    logic       oc_trip = 1'b0;
    logic       load_off = 1'b0;
    logic [7:0] dly_ovchg = 8'd3, dly_ovdsg = 8'd3, dly_ovcur = 8'd1, dly_release = 8'd2;
    logic       chg_fet_en, dsg_fet_en;
    logic [2:0] prot_status;

    int n_chk = 0;
    int n_fail = 0;

    // reference model: 0 OFF, 1 NORMAL, 2 OVCHG, 3 OVDSG, 4 OVCUR
    int m_st = 0;
    int m_cnt [6];

    always #10 clk = ~clk;

    bpp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .pwr_good(pwr_good),
        .four_cell(four_cell), .cell_ov(cell_ov), .cell_uv(cell_uv), .cell_low(cell_low),
        .low_chg_allow(low_chg_allow), .oc_trip(oc_trip), .load_off(load_off),
        .dly_ovchg(dly_ovchg), .dly_ovdsg(dly_ovdsg), .dly_ovcur(dly_ovcur),
        .dly_release(dly_release), .chg_fet_en(chg_fet_en), .dsg_fet_en(dsg_fet_en),
        .prot_status(prot_status)
    );

    function automatic logic [3:0] cells_used();
        return four_cell ? 4'b1111 : 4'b0111;
    endfunction

    function automatic bit qual(bit c, int lim, int cin, output int cout);
        bit h;
        h = sample_tick && c && (cin >= lim);
        if (!c) cout = 0;
        else if (sample_tick && cin < 255) cout = cin + 1;
        else cout = cin;
        return h;
    endfunction

    task automatic model_step();
        bit ovh, uvh, och, ovr, uvr, ldr;
        int nc [6];
        bit ova, uva;
        if (!rst_n) begin
            m_st = 0;
            for (int k = 0; k < 6; k++) m_cnt[k] = 0;
            return;
        end
        ova = |(cell_ov & cells_used());
        uva = |(cell_uv & cells_used());
        ovh = qual(ova, dly_ovchg, m_cnt[0], nc[0]);
        uvh = qual(uva, dly_ovdsg, m_cnt[1], nc[1]);
        och = qual(oc_trip, dly_ovcur, m_cnt[2], nc[2]);
        ovr = qual(!ova && m_st == 2, dly_release, m_cnt[3], nc[3]);
        uvr = qual(!uva && m_st == 3, dly_release, m_cnt[4], nc[4]);
        ldr = qual(load_off && m_st == 4, dly_release, m_cnt[5], nc[5]);
        for (int k = 0; k < 6; k++) m_cnt[k] = nc[k];
        case (m_st)
            0: if (pwr_good) m_st = 1;
            1: if (och) m_st = 4; else if (uvh) m_st = 3; else if (ovh) m_st = 2;
            2: if (och) m_st = 4; else if (uvh) m_st = 3; else if (ovr) m_st = 1;
            3: if (uvr) m_st = 1;
            4: if (ldr) m_st = 1;
            default: m_st = 0;
        endcase
    endtask

    function automatic bit exp_chg();
        bit inh;
        inh = !low_chg_allow && |(cell_low & cells_used());
        return (m_st == 1 || m_st == 3 || m_st == 4) && !inh;
    endfunction

    function automatic bit exp_dsg();
        return m_st == 1 || m_st == 2;
    endfunction

    function automatic logic [2:0] exp_stat();
        return (m_st == 2) ? 3'b001 : (m_st == 3) ? 3'b010 : (m_st == 4) ? 3'b100 : 3'b000;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_out(string req, bit c, bit d, logic [2:0] s);
        chk({req, " chg"}, {7'd0, chg_fet_en}, {7'd0, c});
        chk({req, " dsg"}, {7'd0, dsg_fet_en}, {7'd0, d});
        chk({req, " status"}, {5'd0, prot_status}, {5'd0, s});
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(posedge clk);
            model_step();
            #2;
            chk("model chg", {7'd0, chg_fet_en}, {7'd0, exp_chg()});
            chk("model dsg", {7'd0, dsg_fet_en}, {7'd0, exp_dsg()});
            chk("model status", {5'd0, prot_status}, {5'd0, exp_stat()});
        end
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            sample_tick = 1'b1;
            run(1);
            sample_tick = 1'b0;
            run(1);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset and power-good gating
        run(3);
        chk_out("R1 in reset", 0, 0, 3'b000);
        rst_n = 1'b1;
        run(3);
        chk_out("R1 waiting power", 0, 0, 3'b000);
        pwr_good = 1'b1;
        run(1);
        chk_out("R1 power up", 1, 1, 3'b000);

        // R2: over-charge qualification after D+1 ticks
        cell_ov = 4'b0010;
        ticks(3);
        chk_out("R2 before limit", 1, 1, 3'b000);
        ticks(1);
        chk_out("R2 tripped", 0, 1, 3'b001);
        chk("R12 ovchg bit", {5'd0, prot_status}, 8'h01);

        // R6: release after R+1 clear ticks
        cell_ov = 4'b0000;
        ticks(2);
        chk_out("R6 still held", 0, 1, 3'b001);
        ticks(1);
        chk_out("R6 released", 1, 1, 3'b000);

        // R5: a break restarts the count; R3: over-discharge
        cell_uv = 4'b0001;
        ticks(3);
        cell_uv = 4'b0000;
        run(1);
        cell_uv = 4'b0001;
        ticks(3);
        chk_out("R5 restart", 1, 1, 3'b000);
        ticks(1);
        chk_out("R3 tripped", 1, 0, 3'b010);

        // R7: over-discharge release
        cell_uv = 4'b0000;
        ticks(2);
        chk_out("R7 still held", 1, 0, 3'b010);
        ticks(1);
        chk_out("R7 released", 1, 1, 3'b000);

        // R4 / R8: over-current and load-based release
        oc_trip = 1'b1;
        ticks(2);
        chk_out("R4 tripped", 1, 0, 3'b100);
        oc_trip = 1'b0;
        ticks(5);
        chk_out("R8 no timeout release", 1, 0, 3'b100);
        load_off = 1'b1;
        ticks(2);
        chk_out("R8 load short", 1, 0, 3'b100);
        ticks(1);
        chk_out("R8 released", 1, 1, 3'b000);
        load_off = 1'b0;

        // R9: three-cell mode ignores cell 3; R11: charge inhibit
        dly_ovchg = 8'd0;
        four_cell = 1'b0;
        cell_ov = 4'b1000;
        ticks(2);
        chk_out("R9 cell3 ov ignored", 1, 1, 3'b000);
        cell_low = 4'b1000;
        low_chg_allow = 1'b0;
        run(1);
        chk_out("R9 cell3 low ignored", 1, 1, 3'b000);
        four_cell = 1'b1;
        run(1);
        chk_out("R11 inhibit", 0, 1, 3'b000);
        low_chg_allow = 1'b1;
        run(1);
        chk_out("R11 allowed", 1, 1, 3'b000);
        cell_ov = 4'b0000;
        cell_low = 4'b0000;
        run(1);

        // R10: simultaneous qualification priority
        dly_ovchg = 8'd2; dly_ovdsg = 8'd2; dly_ovcur = 8'd2;
        cell_ov = 4'b0001; cell_uv = 4'b0010; oc_trip = 1'b1;
        ticks(3);
        chk_out("R10 current wins", 1, 0, 3'b100);
        cell_ov = 4'b0000; cell_uv = 4'b0000; oc_trip = 1'b0; load_off = 1'b1;
        ticks(3);
        chk_out("R8 back to normal", 1, 1, 3'b000);
        load_off = 1'b0;
        cell_ov = 4'b0001; cell_uv = 4'b0010;
        ticks(3);
        chk_out("R10 discharge wins", 1, 0, 3'b010);
        cell_ov = 4'b0000; cell_uv = 4'b0000;
        ticks(3);
        chk_out("R7 back to normal", 1, 1, 3'b000);

        // constrained random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if (i % 200 == 0) begin
                dly_ovchg = 8'($urandom % 5);
                dly_ovdsg = 8'($urandom % 5);
                dly_ovcur = 8'($urandom % 5);
                dly_release = 8'($urandom % 5);
            end
            sample_tick = ($urandom % 2) == 0;
            for (int k = 0; k < 4; k++) begin
                if ($urandom % 16 == 0) cell_ov[k] = ~cell_ov[k];
                if ($urandom % 16 == 0) cell_uv[k] = ~cell_uv[k];
                if ($urandom % 40 == 0) cell_low[k] = ~cell_low[k];
            end
            if ($urandom % 12 == 0) oc_trip = ~oc_trip;
            if ($urandom % 12 == 0) load_off = ~load_off;
            if ($urandom % 200 == 0) four_cell = ~four_cell;
            if ($urandom % 50 == 0) low_chg_allow = ~low_chg_allow;
            run(1);
        end
        finish_run();
    end
endmodule